// File: doc/BRIEF.md
# SDRAM Low-Power Entry Sequencer

This block lives inside an SDRAM controller and decides when the memory should be put into self refresh after traffic stops. It watches a transfer-busy flag. Once the flag falls, it either requests self-refresh entry at once or first counts a run of idle cycles. A two-bit idle-delay code picks the behaviour: immediate entry, a short delay, a long delay, or no automatic entry.

The block also holds the extended-mode settings of a low-power SDRAM: output drive strength, temperature-compensated refresh rate and partial-array refresh coverage. The partial-array setting chooses whether a quarter, a half or the whole array keeps being refreshed. The same three values are presented to the initialization logic. When a register write changes any of them, a dirty flag is raised. The next self-refresh entry is then preceded by an extended mode register write that carries the current values.

Commands leave the block on a single request/acknowledge channel. A transfer that starts while the memory is in self refresh triggers a self-refresh exit command. The states are `ST_BUSY` (traffic or waiting for it to stop), `ST_IDLE_COUNT` (counting idle cycles), `ST_EMRS_REQ` (extended mode write requested), `ST_SRE_REQ` (self-refresh entry requested), `ST_SELF_REFRESH` and `ST_SRX_REQ` (exit requested).

The transitions are:
- BUSY to EMRS_REQ or SRE_REQ when the busy flag falls with the immediate code.
- BUSY to IDLE_COUNT when it falls with any other code.
- IDLE_COUNT to BUSY on traffic.
- IDLE_COUNT to EMRS_REQ or SRE_REQ when the delay expires.
- EMRS_REQ to SRE_REQ on acknowledge, or to BUSY if traffic is pending. It stays in EMRS_REQ if the fields change on the acknowledge cycle.
- SRE_REQ to SELF_REFRESH on acknowledge.
- SELF_REFRESH to SRX_REQ on traffic.
- SRX_REQ to BUSY on acknowledge.

Top module: `sdram_lp_sequencer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cmd_req` is 0, `cmd_op` is 0, `in_self_refresh` is 0, and the three mode-field outputs read 0. The idle-delay code resets to 0.
- R2: With idle-delay code 0, `cmd_req` rises in the cycle directly after the last cycle in which `xfer_busy` was high.
- R3: With idle-delay code 1, the entry request rises 64 cycles later than it would with code 0, and not earlier.
- R4: With idle-delay code 2, the entry request rises 128 cycles later than it would with code 0, and not earlier.
- R5: With idle-delay code 3, no entry request (EMRS or self-refresh entry) is ever raised, however long the block stays idle.
- R6: If `xfer_busy` rises during the idle count, the count is discarded and no command is issued. The full delay is measured again from the next falling edge of busy.
- R7: A `cfg_we` write that changes drive strength, temperature or partial-array setting causes the next entry to start with an EMRS request (`cmd_op`=1). During that request the mode outputs carry the written values. Op encodings: 1 = EMRS, 2 = self-refresh entry, 3 = self-refresh exit, 0 = none.
- R8: A write that leaves all three mode fields at their current values does not cause an EMRS. Entry goes straight to a self-refresh entry request (`cmd_op`=2).
- R9: A raised request holds with a stable op until `cmd_ack`. The self-refresh entry request follows an EMRS only after that EMRS has been acknowledged.
- R10: A field change written in the same cycle that the EMRS is acknowledged is not lost. The EMRS request remains raised and now carries the new values.
- R11: A rise of `xfer_busy` in self refresh raises an exit request (`cmd_op`=3) in the next cycle. After the exit is acknowledged, the idle delay restarts when busy next falls.
- R12: `in_self_refresh` is 1 from the cycle after the entry request is acknowledged until the exit request is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_timeout | input | 2 | Idle-delay code written on `cfg_we` |
| cfg_drive | input | DS_W | Drive-strength value written on `cfg_we` |
| cfg_tcsr | input | TCSR_W | Temperature refresh value written on `cfg_we` |
| cfg_pasr | input | PASR_W | Partial-array refresh value written on `cfg_we` |
| xfer_busy | input | 1 | High while a transfer is requested or in progress |
| cmd_ack | input | 1 | Command completion acknowledge |
| cmd_req | output | 1 | Command request |
| cmd_op | output | 2 | Requested command (1 EMRS, 2 enter, 3 exit) |
| emr_drive | output | DS_W | Current drive-strength setting |
| emr_tcsr | output | TCSR_W | Current temperature refresh setting |
| emr_pasr | output | PASR_W | Current partial-array refresh setting |
| in_self_refresh | output | 1 | Memory is in self refresh |

## Verification
The hardest case to reach is a field change that lands exactly in the cycle in which the EMRS is acknowledged. In that cycle the dirty flag must be cleared and set at the same time, with the set winning. The bench waits until the EMRS request is up. It then drives `cmd_ack` and a changing `cfg_we` on the same falling clock edge, so both are sampled at one rising edge. It then checks that the request stays an EMRS carrying the new values. Exact delay boundaries are checked by counting falling edges from the busy drop and sampling one cycle before and at the expected rise.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;

    typedef enum logic [2:0] {
        ST_BUSY,
        ST_IDLE_COUNT,
        ST_EMRS_REQ,
        ST_SRE_REQ,
        ST_SELF_REFRESH,
        ST_SRX_REQ
    } lp_state_t;

    typedef enum logic [1:0] {
        OP_NONE     = 2'd0,
        OP_EMRS     = 2'd1,
        OP_SR_ENTER = 2'd2,
        OP_SR_EXIT  = 2'd3
    } lp_op_t;

    localparam logic [1:0] TMO_NOW   = 2'd0;
    localparam logic [1:0] TMO_SHORT = 2'd1;
    localparam logic [1:0] TMO_LONG  = 2'd2;
    localparam logic [1:0] TMO_OFF   = 2'd3;

endpackage

// File: rtl/lp_cfg_regs.sv
module lp_cfg_regs #(
    parameter int DS_W   = 2,
    parameter int TCSR_W = 2,
    parameter int PASR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_timeout,
    input  logic [DS_W-1:0]   wr_drive,
    input  logic [TCSR_W-1:0] wr_tcsr,
    input  logic [PASR_W-1:0] wr_pasr,
    input  logic              emrs_done,
    output logic [1:0]        timeout,
    output logic [DS_W-1:0]   drive,
    output logic [TCSR_W-1:0] tcsr,
    output logic [PASR_W-1:0] pasr,
    output logic              field_change,
    output logic              dirty
);

    localparam int MODE_W = DS_W + TCSR_W + PASR_W;

    logic [MODE_W-1:0] mode_cur;
    logic [MODE_W-1:0] mode_wr;

    assign mode_cur     = {drive, tcsr, pasr};
    assign mode_wr      = {wr_drive, wr_tcsr, wr_pasr};
    assign field_change = wr_en && (mode_wr != mode_cur);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout <= '0;
            drive   <= '0;
            tcsr    <= '0;
            pasr    <= '0;
        end else if (wr_en) begin
            timeout <= wr_timeout;
            drive   <= wr_drive;
            tcsr    <= wr_tcsr;
            pasr    <= wr_pasr;
        end
    end

    // A change in the acknowledge cycle wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty <= 1'b0;
        end else if (field_change) begin
            dirty <= 1'b1;
        end else if (emrs_done) begin
            dirty <= 1'b0;
        end
    end

endmodule

// File: rtl/lp_idle_timer.sv
module lp_idle_timer
    import lp_seq_pkg::*;
#(
    parameter int SHORT_IDLE = 64,
    parameter int LONG_IDLE  = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       counting,
    input  logic [1:0] code,
    output logic       expired
);

    localparam int CNT_W = $clog2(LONG_IDLE + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // Count value k is seen at the k-th edge after the busy drop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!counting) begin
            cnt <= CNT_W'(1);
        end else if (cnt < CNT_W'(LONG_IDLE)) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    always_comb begin
        unique case (code)
            TMO_NOW:   limit = '0;
            TMO_SHORT: limit = CNT_W'(SHORT_IDLE);
            TMO_LONG:  limit = CNT_W'(LONG_IDLE);
            default:   limit = CNT_W'(LONG_IDLE);
        endcase
    end

    assign expired = (code != TMO_OFF) && (cnt >= limit);

endmodule

// File: rtl/lp_cmd_fsm.sv
module lp_cmd_fsm
    import lp_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xfer_busy,
    input  logic [1:0] timeout,
    input  logic       dirty,
    input  logic       field_change,
    input  logic       expired,
    input  logic       cmd_ack,
    output lp_state_t  state,
    output logic       cmd_req,
    output lp_op_t     cmd_op,
    output logic       in_sr,
    output logic       counting,
    output logic       emrs_done
);

    lp_state_t state_nx;
    lp_state_t entry_st;

    assign entry_st = dirty ? ST_EMRS_REQ : ST_SRE_REQ;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_BUSY;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_BUSY: begin
                if (!xfer_busy) begin
                    state_nx = (timeout == TMO_NOW) ? entry_st : ST_IDLE_COUNT;
                end
            end
            ST_IDLE_COUNT: begin
                if (xfer_busy) begin
                    state_nx = ST_BUSY;
                end else if (expired) begin
                    state_nx = entry_st;
                end
            end
            ST_EMRS_REQ: begin
                if (cmd_ack) begin
                    if (field_change) begin
                        state_nx = ST_EMRS_REQ;
                    end else if (xfer_busy) begin
                        state_nx = ST_BUSY;
                    end else begin
                        state_nx = ST_SRE_REQ;
                    end
                end
            end
            ST_SRE_REQ: begin
                if (cmd_ack) begin
                    state_nx = ST_SELF_REFRESH;
                end
            end
            ST_SELF_REFRESH: begin
                if (xfer_busy) begin
                    state_nx = ST_SRX_REQ;
                end
            end
            ST_SRX_REQ: begin
                if (cmd_ack) begin
                    state_nx = ST_BUSY;
                end
            end
            default: state_nx = ST_BUSY;
        endcase
    end

    always_comb begin
        cmd_req  = 1'b0;
        cmd_op   = OP_NONE;
        in_sr    = 1'b0;
        counting = 1'b0;
        unique case (state)
            ST_BUSY: begin
            end
            ST_IDLE_COUNT: begin
                counting = 1'b1;
            end
            ST_EMRS_REQ: begin
                cmd_req = 1'b1;
                cmd_op  = OP_EMRS;
            end
            ST_SRE_REQ: begin
                cmd_req = 1'b1;
                cmd_op  = OP_SR_ENTER;
            end
            ST_SELF_REFRESH: begin
                in_sr = 1'b1;
            end
            ST_SRX_REQ: begin
                cmd_req = 1'b1;
                cmd_op  = OP_SR_EXIT;
                in_sr   = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign emrs_done = (state == ST_EMRS_REQ) && cmd_ack;

endmodule

// File: rtl/sdram_lp_sequencer.sv
module sdram_lp_sequencer
    import lp_seq_pkg::*;
#(
    parameter int DS_W       = 2,
    parameter int TCSR_W     = 2,
    parameter int PASR_W     = 3,
    parameter int SHORT_IDLE = 64,
    parameter int LONG_IDLE  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_timeout,
    input  logic [DS_W-1:0]   cfg_drive,
    input  logic [TCSR_W-1:0] cfg_tcsr,
    input  logic [PASR_W-1:0] cfg_pasr,
    input  logic              xfer_busy,
    input  logic              cmd_ack,
    output logic              cmd_req,
    output logic [1:0]        cmd_op,
    output logic [DS_W-1:0]   emr_drive,
    output logic [TCSR_W-1:0] emr_tcsr,
    output logic [PASR_W-1:0] emr_pasr,
    output logic              in_self_refresh
);

    logic [1:0] timeout_q;
    logic       dirty_q;
    logic       field_change;
    logic       expired;
    logic       counting;
    logic       emrs_done;
    lp_state_t  state;
    lp_op_t     op_w;

    lp_cfg_regs #(
        .DS_W   (DS_W),
        .TCSR_W (TCSR_W),
        .PASR_W (PASR_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (cfg_we),
        .wr_timeout   (cfg_timeout),
        .wr_drive     (cfg_drive),
        .wr_tcsr      (cfg_tcsr),
        .wr_pasr      (cfg_pasr),
        .emrs_done    (emrs_done),
        .timeout      (timeout_q),
        .drive        (emr_drive),
        .tcsr         (emr_tcsr),
        .pasr         (emr_pasr),
        .field_change (field_change),
        .dirty        (dirty_q)
    );

    lp_idle_timer #(
        .SHORT_IDLE (SHORT_IDLE),
        .LONG_IDLE  (LONG_IDLE)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .counting (counting),
        .code     (timeout_q),
        .expired  (expired)
    );

    lp_cmd_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .xfer_busy    (xfer_busy),
        .timeout      (timeout_q),
        .dirty        (dirty_q),
        .field_change (field_change),
        .expired      (expired),
        .cmd_ack      (cmd_ack),
        .state        (state),
        .cmd_req      (cmd_req),
        .cmd_op       (op_w),
        .in_sr        (in_self_refresh),
        .counting     (counting),
        .emrs_done    (emrs_done)
    );

    assign cmd_op = op_w;

endmodule

// File: rtl/lp_seq_checker.sv
module lp_seq_checker
    import lp_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] timeout,
    input logic       dirty,
    input logic       cmd_req,
    input logic [1:0] cmd_op,
    input logic       cmd_ack,
    input logic       in_sr
);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_ack) |=> (cmd_req && cmd_op == $past(cmd_op))); // R9

    AST_CLEAN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && cmd_op == OP_SR_ENTER && !$past(cmd_req && cmd_op == OP_SR_ENTER))
        |-> (!$past(dirty) || $past(cmd_op == OP_EMRS && cmd_ack))); // R7

    AST_OFF_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cmd_req) && (cmd_op == OP_EMRS || cmd_op == OP_SR_ENTER))
        |-> ($past(timeout) != TMO_OFF)); // R5

    AST_EXIT_IN_SR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && cmd_op == OP_SR_EXIT) |-> in_sr); // R11

    AST_SR_ENTRY_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sr) |-> $past(cmd_req && cmd_op == OP_SR_ENTER && cmd_ack)); // R12

    AST_SR_LEAVE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_sr) |-> $past(cmd_req && cmd_op == OP_SR_EXIT && cmd_ack)); // R12

endmodule

bind sdram_lp_sequencer lp_seq_checker u_lp_seq_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .timeout (timeout_q),
    .dirty   (dirty_q),
    .cmd_req (cmd_req),
    .cmd_op  (cmd_op),
    .cmd_ack (cmd_ack),
    .in_sr   (in_self_refresh)
);

// File: tb/test_sdram_lp_sequencer.sv
module test_sdram_lp_sequencer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_timeout = 2'd0;
    logic [1:0] cfg_drive = 2'd0;
    logic [1:0] cfg_tcsr = 2'd0;
    logic [2:0] cfg_pasr = 3'd0;
    logic       xfer_busy = 1'b1;
    logic       cmd_ack = 1'b0;
    logic       cmd_req;
    logic [1:0] cmd_op;
    logic [1:0] emr_drive;
    logic [1:0] emr_tcsr;
    logic [2:0] emr_pasr;
    logic       in_self_refresh;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    sdram_lp_sequencer i_sdram_lp_sequencer (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_we          (cfg_we),
        .cfg_timeout     (cfg_timeout),
        .cfg_drive       (cfg_drive),
        .cfg_tcsr        (cfg_tcsr),
        .cfg_pasr        (cfg_pasr),
        .xfer_busy       (xfer_busy),
        .cmd_ack         (cmd_ack),
        .cmd_req         (cmd_req),
        .cmd_op          (cmd_op),
        .emr_drive       (emr_drive),
        .emr_tcsr        (emr_tcsr),
        .emr_pasr        (emr_pasr),
        .in_self_refresh (in_self_refresh)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [1:0] code, input logic [1:0] ds,
                             input logic [1:0] tc, input logic [2:0] pa);
        @(negedge clk);
        cfg_we = 1'b1; cfg_timeout = code;
        cfg_drive = ds; cfg_tcsr = tc; cfg_pasr = pa;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_ack();
        cmd_ack = 1'b1;
        @(negedge clk);
        cmd_ack = 1'b0;
    endtask

    // Drops busy and checks the entry request rises after exactly delay+1 edges.
    task automatic drop_and_measure(input int delay, input int exp_op, input string tag);
        int early = 0;
        @(negedge clk);
        xfer_busy = 1'b0;
        for (int i = 0; i < delay; i++) begin
            @(negedge clk);
            if (cmd_req) early++;
        end
        chk({tag, " no early request"}, early, 0);
        @(negedge clk);
        chk({tag, " request at delay"}, cmd_req, 1);
        chk({tag, " op at delay"}, cmd_op, exp_op);
    endtask

    task automatic enter_sr(input string tag);
        pulse_ack();
        chk({tag, " R12 in_self_refresh after entry ack"}, in_self_refresh, 1);
        chk({tag, " R12 request drops"}, cmd_req, 0);
    endtask

    task automatic leave_sr(input string tag);
        xfer_busy = 1'b1;
        @(negedge clk);
        chk({tag, " R11 exit request"}, cmd_req, 1);
        chk({tag, " R11 exit op"}, cmd_op, 3);
        chk({tag, " R12 still in SR during exit req"}, in_self_refresh, 1);
        pulse_ack();
        chk({tag, " R12 SR cleared after exit ack"}, in_self_refresh, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 req in reset", cmd_req, 0);
        chk("R1 op in reset", cmd_op, 0);
        chk("R1 SR in reset", in_self_refresh, 0);
        chk("R1 fields in reset", {emr_drive, emr_tcsr, emr_pasr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req after reset", cmd_req, 0);
    endtask

    task automatic t_immediate();
        write_cfg(2'd0, 2'd0, 2'd0, 3'd0);
        drop_and_measure(0, 2, "R2 R8 code0");
        enter_sr("R2");
        leave_sr("R2");
        repeat (3) @(negedge clk);
        drop_and_measure(0, 2, "R11 restart code0");
        enter_sr("R11");
        leave_sr("R11");
    endtask

    task automatic t_delay(input logic [1:0] code, input int delay, input string tag);
        write_cfg(code, 2'd0, 2'd0, 3'd0);
        drop_and_measure(delay, 2, tag);
        enter_sr(tag);
        leave_sr(tag);
    endtask

    task automatic t_restart();
        int seen = 0;
        write_cfg(2'd1, 2'd0, 2'd0, 3'd0);
        @(negedge clk);
        xfer_busy = 1'b0;
        repeat (40) begin
            @(negedge clk);
            if (cmd_req) seen++;
        end
        xfer_busy = 1'b1;
        repeat (2) begin
            @(negedge clk);
            if (cmd_req) seen++;
        end
        chk("R6 no command on interrupted count", seen, 0);
        drop_and_measure(64, 2, "R6 full delay after restart");
        enter_sr("R6");
        leave_sr("R6");
    endtask

    task automatic t_disabled();
        int seen = 0;
        write_cfg(2'd3, 2'd0, 2'd0, 3'd0);
        @(negedge clk);
        xfer_busy = 1'b0;
        repeat (300) begin
            @(negedge clk);
            if (cmd_req) seen++;
        end
        chk("R5 no entry with code 3", seen, 0);
        chk("R5 not in SR with code 3", in_self_refresh, 0);
        xfer_busy = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_emrs();
        write_cfg(2'd0, 2'd2, 2'd1, 3'd5);
        drop_and_measure(0, 1, "R7 EMRS first");
        chk("R7 EMRS drive value", emr_drive, 2);
        chk("R7 EMRS tcsr value", emr_tcsr, 1);
        chk("R7 EMRS pasr value", emr_pasr, 5);
        repeat (4) @(negedge clk);
        chk("R9 EMRS held without ack", cmd_req, 1);
        chk("R9 EMRS op stable", cmd_op, 1);
        pulse_ack();
        chk("R9 entry after EMRS ack", cmd_req, 1);
        chk("R9 entry op after EMRS ack", cmd_op, 2);
        enter_sr("R7");
        leave_sr("R7");
        write_cfg(2'd0, 2'd2, 2'd1, 3'd5);
        drop_and_measure(0, 2, "R8 unchanged write no EMRS");
        enter_sr("R8");
        leave_sr("R8");
    endtask

    task automatic t_race();
        write_cfg(2'd0, 2'd1, 2'd3, 3'd2);
        drop_and_measure(0, 1, "R10 first EMRS");
        chk("R10 first EMRS fields", {emr_drive, emr_tcsr, emr_pasr}, {2'd1, 2'd3, 3'd2});
        cmd_ack = 1'b1;
        cfg_we = 1'b1; cfg_timeout = 2'd0;
        cfg_drive = 2'd3; cfg_tcsr = 2'd0; cfg_pasr = 3'd6;
        @(negedge clk);
        cmd_ack = 1'b0;
        cfg_we = 1'b0;
        chk("R10 EMRS re-requested", cmd_req, 1);
        chk("R10 op still EMRS", cmd_op, 1);
        chk("R10 new fields carried", {emr_drive, emr_tcsr, emr_pasr}, {2'd3, 2'd0, 3'd6});
        pulse_ack();
        chk("R10 entry after second EMRS", cmd_op, 2);
        enter_sr("R10");
        leave_sr("R10");
    endtask

    initial begin
        t_reset();
        t_immediate();
        t_delay(2'd1, 64, "R3 code1");
        t_delay(2'd2, 128, "R4 code2");
        t_restart();
        t_disabled();
        t_emrs();
        t_race();
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule